// File: doc/BRIEF.md
# Vector Widening Extension Unit

This execution unit serves a 256-bit SIMD datapath. It accepts one 32-bit instruction word at a time, together with the value of the source vector register. It recognises twelve widening operations. Each operation reads the low-order narrow elements of the source across the full register width, not per 128-bit half. It then widens every one of them into a wider element of a 256-bit result, by sign extension or zero extension.

The result and the destination register index are registered. They appear one cycle after the request, marked by a one-cycle output valid pulse. A request that does not decode to one of the twelve operations raises an illegal-opcode pulse in the same cycle slot and leaves the previous result untouched. The whole result is formed from the sampled source before it is written. A write-back into the register that supplied the source therefore stays correct.

Top module: `vwiden_unit`

## Requirements
- R1: An instruction is legal only when bits [31:15] equal 01110110100111110 and the minor code in bits [14:10] lies in the range 4 to 15 inclusive.
- R2: Minor codes 4, 5, 6, 7, 8 and 9 select signed widening of byte to 16-bit, byte to 32-bit, byte to 64-bit, 16-bit to 32-bit, 16-bit to 64-bit and 32-bit to 64-bit respectively.
- R3: Minor codes 10 to 15 select the same six width pairs in the same order, but with zero extension.
- R4: Result element i of width D is taken from source element i of width S, for i from 0 to 256/D-1. Source bits above element 256/D-1 have no effect on the result.
- R5: A signed operation fills the upper D-S bits of each result element with bit S-1 of its source element. An unsigned operation fills them with zeros.
- R6: An illegal request (R1 not met) produces out_illegal high for one cycle in the cycle after the request, with out_valid low. out_result and out_rd keep their previous values.
- R7: A legal request produces out_valid high for exactly the next cycle, with out_result holding the widened value and out_rd equal to bits [4:0] of the request's instruction.
- R8: A synchronous active-high reset drives out_valid and out_illegal low and clears out_result and out_rd to zero.
- R9: In a cycle after one with in_valid low, out_valid and out_illegal are low, and out_result and out_rd are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| insn | input | 32 | Instruction word |
| src_vec | input | 256 | Source vector register value |
| out_valid | output | 1 | Result valid pulse |
| out_illegal | output | 1 | Illegal-opcode pulse |
| out_result | output | 256 | Widened result |
| out_rd | output | 5 | Destination register index |

## Verification
The bound checker watches, on every cycle, the timing relations: the one-cycle pulse after a request, out_rd matching the request's destination field, the exclusivity of the valid and illegal pulses, and the result holding through idle and illegal cycles. It also watches the zero upper bytes of the unsigned byte-to-64-bit result. The element-by-element values of all twelve operations, the sign versus zero fill, and the fact that the upper source half has no effect can only be shown by the bench. The bench sweeps all 32 minor codes against corner and random sources and checks each result against its own arithmetic model.

// File: rtl/vwiden_unit.sv
module vwiden_unit #(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [VLEN-1:0] src_vec,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [VLEN-1:0] out_result,
  output logic [4:0]      out_rd
);
  localparam logic [16:0] OPC_PREFIX = 17'b01110110100111110;
  localparam int NPAIR = 6;

  logic [4:0] minor;
  logic       hit, sgn_rng, uns_rng, legal, sext;
  logic [2:0] pair;
  logic [VLEN-1:0] wide [NPAIR];

  assign minor   = insn[14:10];
  assign hit     = insn[31:15] == OPC_PREFIX;
  assign sgn_rng = (minor >= 5'd4)  && (minor <= 5'd9);
  assign uns_rng = (minor >= 5'd10) && (minor <= 5'd15);
  assign legal   = hit && (sgn_rng || uns_rng);
  assign sext    = sgn_rng;

  always_comb begin
    case (minor)
      5'd4,  5'd10: pair = 3'd0;
      5'd5,  5'd11: pair = 3'd1;
      5'd6,  5'd12: pair = 3'd2;
      5'd7,  5'd13: pair = 3'd3;
      5'd8,  5'd14: pair = 3'd4;
      5'd9,  5'd15: pair = 3'd5;
      default:      pair = 3'd0;
    endcase
  end

  for (genvar v = 0; v < NPAIR; v++) begin : g_pair
    localparam int SW = (v < 3) ? 8 : ((v < 5) ? 16 : 32);
    localparam int DW = (v == 0) ? 16 : ((v == 1 || v == 3) ? 32 : 64);
    for (genvar e = 0; e < VLEN / DW; e++) begin : g_elem
      assign wide[v][e*DW +: DW] =
        {{(DW-SW){sext & src_vec[e*SW+SW-1]}}, src_vec[e*SW +: SW]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_rd      <= '0;
    end else begin
      out_valid   <= in_valid && legal;
      out_illegal <= in_valid && !legal;
      if (in_valid && legal) begin
        out_result <= wide[pair];
        out_rd     <= insn[4:0];
      end
    end
  end
endmodule

module vwiden_unit_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [31:0]     insn,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [VLEN-1:0] out_result,
  input logic [4:0]      out_rd
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_illegal)); // R8
  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (out_valid || out_illegal) |-> $past(in_valid)); // R9
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal)); // R6
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_rd == $past(insn[4:0]))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_result) && $stable(out_rd))); // R9
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> ($stable(out_result) && $stable(out_rd))); // R6
  AST_ZEXT_TOP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(insn[14:10]) == 5'd12) |-> (out_result[VLEN-1:VLEN-56] == '0)); // R3
endmodule

bind vwiden_unit vwiden_unit_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
  .out_valid(out_valid), .out_illegal(out_illegal),
  .out_result(out_result), .out_rd(out_rd)
);

// File: tb/vwiden_unit_tb.sv
`timescale 1ns/1ps
module vwiden_unit_tb;
  localparam logic [16:0] PFX = 17'b01110110100111110;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [255:0] src_vec = '0;
  logic out_valid, out_illegal;
  logic [255:0] out_result;
  logic [4:0] out_rd;
  int n_run = 0, n_fail = 0;
  logic [255:0] held_res = '0;
  logic [4:0] held_rd = '0;

  always #4 clk = ~clk;

  vwiden_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .src_vec(src_vec),
    .out_valid(out_valid), .out_illegal(out_illegal),
    .out_result(out_result), .out_rd(out_rd)
  );

  function automatic logic [255:0] model(input logic [4:0] m, input logic [255:0] s);
    logic [255:0] r = '0;
    int v = (m >= 10) ? int'(m) - 10 : int'(m) - 4;
    bit sg = (m < 10);
    int sw = (v < 3) ? 8 : ((v < 5) ? 16 : 32);
    int dw = (v == 0) ? 16 : ((v == 1 || v == 3) ? 32 : 64);
    for (int e = 0; e < 256 / dw; e++)
      for (int b = 0; b < dw; b++)
        r[e*dw+b] = (b < sw) ? s[e*sw+b] : (sg ? s[e*sw+sw-1] : 1'b0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [255:0] s);
    bit lg;
    logic [4:0] m;
    m  = w[14:10];
    lg = (w[31:15] == PFX) && (m >= 5'd4) && (m <= 5'd15);
    @(negedge clk);
    in_valid = 1'b1; insn = w; src_vec = s;
    @(negedge clk);
    in_valid = 1'b0; src_vec = ~s;
    if (lg) begin
      chk(out_valid && !out_illegal, "R7 R1", {254'd0, out_valid, out_illegal}, 256'd2);
      chk(out_rd == w[4:0], "R7", 256'(out_rd), 256'(w[4:0]));
      if (m < 10)
        chk(out_result == model(m, s), "R2 R4 R5", out_result, model(m, s));
      else
        chk(out_result == model(m, s), "R3 R4 R5", out_result, model(m, s));
      held_res = model(m, s);
      held_rd  = w[4:0];
    end else begin
      chk(!out_valid && out_illegal, "R6 R1", {254'd0, out_valid, out_illegal}, 256'd1);
      chk(out_result == held_res, "R6", out_result, held_res);
      chk(out_rd == held_rd, "R6", 256'(out_rd), 256'(held_rd));
    end
    @(negedge clk);
    chk(!out_valid && !out_illegal, "R9", {254'd0, out_valid, out_illegal}, 256'd0);
    chk(out_result == held_res && out_rd == held_rd, "R9", out_result, held_res);
  endtask

  initial begin
    logic [255:0] srcs [6];
    srcs[0] = {32{8'h80}};
    srcs[1] = {32{8'hFF}};
    srcs[2] = {16{16'h8000}};
    srcs[3] = {8{32'h80000000}};
    srcs[4] = {128'h0, 128'h7F01_80FE_0000_FFFF_8000_7FFF_1234_ABCD};
    srcs[5] = '0;
    for (int k = 0; k < 8; k++) srcs[5][k*32 +: 32] = $urandom;

    repeat (3) @(negedge clk);
    chk(!out_valid && !out_illegal && out_result == '0 && out_rd == '0, "R8",
        out_result, 256'd0);
    rst = 1'b0;

    for (int m = 0; m < 32; m++)
      for (int k = 0; k < 6; k++)
        apply({PFX, 5'(m), 5'(k + 3), 5'((m + k) % 32)}, srcs[k]);

    // R4: upper half of the source has no effect
    for (int m = 4; m < 16; m++) begin
      logic [255:0] a;
      a = {$urandom, $urandom, $urandom, $urandom, 128'h0F0E_8D0C_F00B_0A09_8807_0605_0403_0281};
      apply({PFX, 5'(m), 5'd1, 5'(m)}, a);
      apply({PFX, 5'(m), 5'd1, 5'(m + 1)}, {~a[255:128], a[127:0]});
    end

    for (int r = 0; r < 40; r++) begin
      logic [255:0] a;
      for (int k = 0; k < 8; k++) a[k*32 +: 32] = $urandom;
      apply({PFX, 5'(4 + (r % 12)), 5'd7, 5'(r)}, a);
    end

    // R1: prefix mismatch is illegal even with a good minor code
    apply({PFX ^ 17'h00001, 5'd4, 5'd0, 5'd9}, srcs[5]);
    apply({PFX ^ 17'h10000, 5'd15, 5'd0, 5'd9}, srcs[5]);
    apply({PFX, 5'd2, 5'd0, 5'd30}, srcs[5]);

    @(negedge clk);
    in_valid = 1'b1; insn = {PFX, 5'd6, 5'd0, 5'd5}; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    chk(!out_valid && !out_illegal && out_result == '0 && out_rd == '0, "R8",
        out_result, 256'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule